// File: doc/BRIEF.md
# Matrix-Vector Multiply-Add Engine

The engine evaluates y = 2·A·x + b for a 16×16 matrix A and 16-element vectors x, b and y, all made of 8-bit unsigned elements. The two vectors x and b are presented as steady 128-bit parallel inputs. The matrix sits in an external read-only memory that holds one full row per 128-bit word. The engine drives a 4-bit row address into that memory and takes the returned row from a 128-bit data input.

Once reset is released, the engine walks the row address from 0 to 15, one row per clock. It pairs each returned row with the index of the address that fetched it. All 16 element products of a row are formed in parallel, summed, doubled and offset by the matching element of b. The result is kept modulo 256 and stored in its byte slot of the packed output. When the last row has been written, a done flag rises. The output and the flag then hold until the next reset.

Top module: `mvm_engine`

## Requirements
- R1: Output element i, in bits [8i+7:8i] of `y_vec`, equals (2 · Σk row_i[k]·x[k] + b[i]) mod 256. Element k of every 128-bit bus (`x_vec`, `b_vec`, `row_data`, `y_vec`) sits in bits [8k+7:8k].
- R2: All arithmetic wraps modulo 256 and has no overflow indication. For example, with every element of A, x and b equal to 0xFF, every output element is 0x1F.
- R3: `row_addr` is 0 while reset is applied. It then rises by one on each rising edge until it reaches 15, and stays at 15.
- R4: The row for address n arrives on `row_data` one clock after `row_addr` shows n. The engine uses that row for output element n.
- R5: `done` is 0 until all 16 elements are valid. It rises on the 17th rising edge after reset is released.
- R6: Once `done` is 1, `done` and `y_vec` hold their values whatever `row_data` carries, until the next reset.
- R7: Reset is active high and asynchronous. Raising `rst` between clock edges clears `done`, `y_vec` and `row_addr` to 0 without waiting for a clock edge.
- R8: A reset applied partway through a computation restarts the sequence from row 0. The result is then formed only from the rows fetched after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| x_vec | input | 128 | Vector x, 16 packed bytes, held steady |
| b_vec | input | 128 | Vector b, 16 packed bytes, held steady |
| row_data | input | 128 | Matrix row returned by memory, one cycle after its address |
| row_addr | output | 4 | Row address driven to the memory |
| y_vec | output | 128 | Result vector, 16 packed bytes, valid while done is 1 |
| done | output | 1 | High once every result element is valid |

## Verification
Two kinds of event share a clock edge. First, the write of the last element (row 15) and the rise of `done` happen on the same edge. Second, each row is consumed on the same edge that advances the address to the next row. The bench provokes both with a memory model that has a true one-cycle read latency and matrices whose rows all differ. A one-cycle misalignment between row and index therefore shows up as wrong output bytes. The bench counts edges from reset release and requires `done` to be low after edge 16 and high after edge 17. At that moment it requires byte 15 to be correct, and it then changes the memory contents to show that nothing further is written.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

    // Default geometry of the engine
    localparam int unsigned MVM_N_ELEM = 16;
    localparam int unsigned MVM_ELEM_W = 8;

    // Phases of the row sequencer
    typedef enum logic [1:0] {
        SEQ_ISSUE = 2'd0,   // addresses still being presented
        SEQ_DRAIN = 2'd1,   // last row in flight from memory
        SEQ_IDLE  = 2'd2    // all rows consumed, nothing more to do
    } seq_phase_e;

    // Final step of an element: double the dot product, add the offset, wrap
    function automatic logic [MVM_ELEM_W-1:0] scale_offset(
        input logic [MVM_ELEM_W-1:0] dot,
        input logic [MVM_ELEM_W-1:0] offs
    );
        logic [MVM_ELEM_W-1:0] dbl;
        dbl = {dot[MVM_ELEM_W-2:0], 1'b0};
        return dbl + offs;
    endfunction

endpackage

// File: rtl/mvm_addr_seq.sv
module mvm_addr_seq
    import mvm_pkg::*;
#(
    parameter int unsigned N_ELEM = MVM_N_ELEM,
    localparam int unsigned AW    = $clog2(N_ELEM)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] row_addr,
    output logic          tag_vld,
    output logic [AW-1:0] tag_idx
);

    localparam logic [AW-1:0] LAST_ROW = AW'(N_ELEM - 1);

    // Tag travelling alongside the memory read: which row is arriving now
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] idx;
    } row_tag_t;

    seq_phase_e phase_q;
    logic [AW-1:0] addr_q;
    row_tag_t tag_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase_q <= SEQ_ISSUE;
            addr_q  <= '0;
            tag_q   <= '0;
        end else begin
            case (phase_q)
                SEQ_ISSUE: begin
                    tag_q.vld <= 1'b1;
                    tag_q.idx <= addr_q;
                    if (addr_q == LAST_ROW) begin
                        phase_q <= SEQ_DRAIN;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                SEQ_DRAIN: begin
                    tag_q.vld <= 1'b0;
                    phase_q   <= SEQ_IDLE;
                end
                default: begin
                    tag_q.vld <= 1'b0;
                end
            endcase
        end
    end

    assign row_addr = addr_q;
    assign tag_vld  = tag_q.vld;
    assign tag_idx  = tag_q.idx;

endmodule

// File: rtl/mvm_row_dot.sv
module mvm_row_dot
    import mvm_pkg::*;
#(
    parameter int unsigned N_ELEM = MVM_N_ELEM,
    parameter int unsigned ELEM_W = MVM_ELEM_W,
    localparam int unsigned BUS_W = N_ELEM * ELEM_W
) (
    input  logic [BUS_W-1:0]  row,
    input  logic [BUS_W-1:0]  x_vec,
    input  logic [ELEM_W-1:0] offs,
    output logic [ELEM_W-1:0] result
);

    logic [ELEM_W-1:0] prod [N_ELEM];

    // One multiplier per column; only the low byte of each product matters
    for (genvar g = 0; g < N_ELEM; g++) begin : g_mul
        logic [2*ELEM_W-1:0] full;
        assign full    = row[g*ELEM_W +: ELEM_W] * x_vec[g*ELEM_W +: ELEM_W];
        assign prod[g] = full[ELEM_W-1:0];
    end

    logic [ELEM_W-1:0] dot;
    always_comb begin
        dot = '0;
        for (int k = 0; k < int'(N_ELEM); k++) begin
            dot = dot + prod[k];
        end
    end

    logic [ELEM_W-1:0] dbl;
    assign dbl    = {dot[ELEM_W-2:0], 1'b0};
    assign result = dbl + offs;

endmodule

// File: rtl/mvm_result_bank.sv
module mvm_result_bank
    import mvm_pkg::*;
#(
    parameter int unsigned N_ELEM = MVM_N_ELEM,
    parameter int unsigned ELEM_W = MVM_ELEM_W,
    localparam int unsigned AW    = $clog2(N_ELEM),
    localparam int unsigned BUS_W = N_ELEM * ELEM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [ELEM_W-1:0] wr_data,
    output logic [BUS_W-1:0]  y_vec,
    output logic              done
);

    localparam logic [AW-1:0] LAST_ROW = AW'(N_ELEM - 1);

    // One byte register per output slot
    for (genvar g = 0; g < N_ELEM; g++) begin : g_slot
        logic [ELEM_W-1:0] slot_q;
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                slot_q <= wr_data;
            end
        end
        assign y_vec[g*ELEM_W +: ELEM_W] = slot_q;
    end

    logic done_q;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (wr_en && (wr_idx == LAST_ROW)) begin
            done_q <= 1'b1;
        end
    end

    assign done = done_q;

endmodule

// File: rtl/mvm_engine.sv
module mvm_engine
    import mvm_pkg::*;
#(
    parameter int unsigned N_ELEM = MVM_N_ELEM,
    parameter int unsigned ELEM_W = MVM_ELEM_W,
    localparam int unsigned AW    = $clog2(N_ELEM),
    localparam int unsigned BUS_W = N_ELEM * ELEM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] x_vec,
    input  logic [BUS_W-1:0] b_vec,
    input  logic [BUS_W-1:0] row_data,
    output logic [AW-1:0]    row_addr,
    output logic [BUS_W-1:0] y_vec,
    output logic             done
);

    logic          tag_vld;
    logic [AW-1:0] tag_idx;

    mvm_addr_seq #(.N_ELEM(N_ELEM)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .row_addr (row_addr),
        .tag_vld  (tag_vld),
        .tag_idx  (tag_idx)
    );

    logic [ELEM_W-1:0] offs;
    assign offs = b_vec[tag_idx*ELEM_W +: ELEM_W];

    logic [ELEM_W-1:0] elem;
    mvm_row_dot #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_dot (
        .row    (row_data),
        .x_vec  (x_vec),
        .offs   (offs),
        .result (elem)
    );

    mvm_result_bank #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tag_vld),
        .wr_idx  (tag_idx),
        .wr_data (elem),
        .y_vec   (y_vec),
        .done    (done)
    );

endmodule

// File: rtl/mvm_engine_chk.sv
module mvm_engine_chk #(
    parameter int unsigned N_ELEM = 16,
    parameter int unsigned ELEM_W = 8,
    localparam int unsigned AW    = $clog2(N_ELEM),
    localparam int unsigned BUS_W = N_ELEM * ELEM_W,
    localparam int unsigned CW    = $clog2(N_ELEM + 2) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    row_addr,
    input logic [BUS_W-1:0] y_vec,
    input logic             done
);

    localparam logic [AW-1:0] LAST_ROW = AW'(N_ELEM - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(N_ELEM + 2);
    localparam logic [CW-1:0] DONE_AT  = CW'(N_ELEM + 1);

    // Edges seen since reset release, saturating
    logic [CW-1:0] edge_cnt;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            edge_cnt <= '0;
        end else if (edge_cnt != CNT_MAX) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // R7: while reset is high everything sits at its cleared value
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |-> (row_addr == '0 && !done && y_vec == '0));

    // R3: address steps by one until the last row
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (row_addr != LAST_ROW) |=> (row_addr == $past(row_addr) + 1'b1));

    // R3: address parks on the last row
    p_addr_park_r3: assert property (@(posedge clk) disable iff (rst)
        (row_addr == LAST_ROW) |=> (row_addr == LAST_ROW));

    // R5: done rises exactly after the 17th edge following release
    p_done_time_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (edge_cnt == DONE_AT));

    // R6: the result and the flag hold once done
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(y_vec)));

endmodule

bind mvm_engine mvm_engine_chk #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .row_addr (row_addr),
    .y_vec    (y_vec),
    .done     (done)
);

// File: tb/test_mvm_engine.sv
`timescale 1ns/1ps
module test_mvm_engine;

    localparam int N = 16;
    localparam int W = 8;
    localparam int NCASE = 5;
    // kind: 0 pattern, 1 everything 0xFF, 2 matrix zero, 3 x zero
    localparam int CASE_KIND [NCASE] = '{0, 1, 2, 3, 0};
    localparam int CASE_SEED [NCASE] = '{3, 0, 5, 9, 41};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N*W-1:0] x_vec = '0;
    logic [N*W-1:0] b_vec = '0;
    logic [N*W-1:0] row_data;
    logic [3:0]     row_addr;
    logic [N*W-1:0] y_vec;
    logic           done;

    logic [N*W-1:0] mem [N];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) row_data <= mem[row_addr];

    mvm_engine i_mvm_engine (
        .clk(clk), .rst(rst), .x_vec(x_vec), .b_vec(b_vec),
        .row_data(row_data), .row_addr(row_addr), .y_vec(y_vec), .done(done)
    );

    function automatic logic [7:0] gen(int seed, int sel, int r, int c);
        return 8'((seed * 29 + sel * 71 + r * 17 + c * 11 + r * c * 3 + 1) & 255);
    endfunction

    function automatic logic [7:0] ref_elem(int i);
        logic [7:0] s;
        s = '0;
        for (int k = 0; k < N; k++) s = 8'(s + mem[i][8*k +: 8] * x_vec[8*k +: 8]);
        return 8'(2 * s + b_vec[8*i +: 8]);
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(int kind, int seed);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                mem[r][8*c +: 8] = (kind == 1) ? 8'hFF : (kind == 2) ? 8'h00 : gen(seed, 0, r, c);
        for (int c = 0; c < N; c++) begin
            x_vec[8*c +: 8] = (kind == 1) ? 8'hFF : (kind == 3) ? 8'h00 : gen(seed, 1, 0, c);
            b_vec[8*c +: 8] = (kind == 1) ? 8'hFF : gen(seed, 2, 0, c);
        end
    endtask

    // Release reset and follow the 17 edges, checking address and done timing
    task automatic run_and_time(string tag);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= N + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            check({"R3 addr ", tag}, 128'(row_addr), 128'((k < N) ? k : N - 1));
            if (k >= N) check({"R5 done ", tag}, 128'(done), 128'(k == N + 1));
        end
    endtask

    task automatic check_y(string req);
        for (int i = 0; i < N; i++) check(req, 128'(y_vec[8*i +: 8]), 128'(ref_elem(i)));
    endtask

    initial begin
        logic [N*W-1:0] held;
        for (int r = 0; r < N; r++) mem[r] = '0;
        repeat (3) @(negedge clk);
        // R7: cleared state under reset
        check("R7 reset y", y_vec, '0);
        check("R7 reset done", 128'(done), 128'(0));
        check("R3 reset addr", 128'(row_addr), 128'(0));

        // Table walk: each case computed, timed and then held
        for (int t = 0; t < NCASE; t++) begin
            rst = 1'b1;
            load(CASE_KIND[t], CASE_SEED[t]);
            @(negedge clk);
            run_and_time("table");
            // R4: row n paired with element n; R1 general result
            check_y((CASE_KIND[t] == 1) ? "R2 wrap" : "R1 R4 result");
            if (CASE_KIND[t] == 1) check("R2 all-FF", y_vec, {N{8'h1F}});
            if (CASE_KIND[t] == 2) check("R1 zero matrix gives b", y_vec, b_vec);
            // R6: memory changes after done must not reach the output
            held = y_vec;
            for (int r = 0; r < N; r++) mem[r] = ~mem[r];
            repeat (6) @(negedge clk);
            check("R6 hold y", y_vec, held);
            check("R6 hold done", 128'(done), 128'(1));
        end

        // R7: asynchronous reset between edges
        @(negedge clk);
        #1 rst = 1'b1;
        #1;
        check("R7 async y", y_vec, '0);
        check("R7 async done", 128'(done), 128'(0));
        check("R7 async addr", 128'(row_addr), 128'(0));

        // R8: reset partway through restarts from row 0 with new contents
        load(0, 77);
        @(negedge clk);
        rst = 1'b0;
        repeat (7) @(negedge clk);
        check("R8 midrun not done", 128'(done), 128'(0));
        rst = 1'b1;
        load(0, 123);
        @(negedge clk);
        check("R8 restart addr", 128'(row_addr), 128'(0));
        run_and_time("restart");
        check_y("R8 restart result");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule